// File: doc/BRIEF.md
# Dual-Channel High/Low Tick PWM

This peripheral drives two independent pulse outputs, A and B, from three 32-bit registers on a simple synchronous read/write bus. Each channel has its own count word that gives the length of the high phase and of the low phase in divided ticks. A single shared control word holds, for each channel, a clock-source select, a 7-bit prescaler, a clock gate and an output enable.

Each channel takes one of four tick-enable inputs, which stand for four clock sources and are synchronous to the bus clock. The selected ticks go through a divide-by-(N+1) prescaler. The divided tick steps a phase counter, which holds the output high for the high count and then low for the low count, over and over. A count word written while the channel runs is used only from the next period boundary, so no pulse is ever cut short or stretched.

Top module: `dual_tick_pwm`

## Requirements
- R1: The channel A count word is at byte offset 0x0, the channel B count word at 0x4 and the control word at 0x8, selected by bus_addr[3:2]. A write to any of them reads back on the next cycle. Offset 0xC reads as zero.
- R2: Control word bits that have no function (bits 2, 3 and 24 to 31, mask 0x00FFFFF3 kept) read as zero whatever was written.
- R3: Control bit 0 (A) and bit 1 (B) are output enables, and bit 15 (A) and bit 23 (B) are clock gates. A channel runs only when both of its bits are set. While it does not run, its output is low in the same cycle and its prescaler and counters are held cleared.
- R4: Control bits [5:4] (A) and [7:6] (B) pick which of the four src_tick_i bits clocks the channel.
- R5: Control bits [14:8] (A) and [22:16] (B) hold a prescaler value N. The channel then advances once every N+1 selected ticks.
- R6: In a count word, bits [31:16] are the high count H and bits [15:0] are the low count L. A running channel outputs H divided ticks high and then L divided ticks low, repeating, and each period begins with its high phase.
- R7: H=0 with L≠0 gives a constant low output. L=0 with H≠0 gives a constant high output. H=L=0 gives a low output.
- R8: A count word written while the channel runs takes effect only at the end of the current period. A word written while the channel is idle is used from the moment it is enabled.
- R9: The two channels run independently, each with its own period, prescaler and source.
- R10: A running output changes level only after a divided tick, one cycle after the channel starts, or when the channel stops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en_i | input | 1 | Bus access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 4 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| src_tick_i | input | 4 | Per-source single-cycle tick enables |
| pwm_a_o | output | 1 | Channel A output |
| pwm_b_o | output | 1 | Channel B output |

## Verification
The hardest case to reach is a count word replaced in the middle of a running period. The bench has to wait for an observed rising edge of the output and then issue the bus write a few cycles into the high phase. It then checks that the old high and low lengths finish in full before the new lengths show. Random configurations are also run on tick sources that fire every one, two or three cycles. This places prescaler wrap points at different offsets from the bus writes that start each channel, and the bench measures only steady-state periods.

// File: rtl/dtp_pkg.sv
package dtp_pkg;
    localparam int CNT_W   = 16;
    localparam int DIV_W   = 7;
    localparam int SEL_W   = 2;
    localparam int NSRC    = 1 << SEL_W;
    localparam int NCH     = 2;
    localparam int REG_W   = 32;

    // Writable control bits: enables [1:0], selects [7:4], prescalers and gates [23:8]
    localparam logic [REG_W-1:0] CTRL_MASK = 32'h00FF_FFF3;

    typedef struct packed {
        logic [CNT_W-1:0] hi;
        logic [CNT_W-1:0] lo;
    } cnt_word_t;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             clk_en;
        logic [SEL_W-1:0] sel;
        logic             out_en;
    } ch_cfg_t;

    function automatic int oe_bit(input int ch);
        return ch;
    endfunction
    function automatic int sel_lsb(input int ch);
        return 4 + SEL_W * ch;
    endfunction
    function automatic int div_lsb(input int ch);
        return 8 + 8 * ch;
    endfunction
    function automatic int gate_bit(input int ch);
        return 15 + 8 * ch;
    endfunction
endpackage

// File: rtl/dtp_regfile.sv
module dtp_regfile
    import dtp_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_en_i,
    input  logic                  bus_wr_i,
    input  logic [3:0]            bus_addr_i,
    input  logic [REG_W-1:0]      bus_wdata_i,
    output logic [REG_W-1:0]      bus_rdata_o,
    output cnt_word_t [NCH-1:0]   word_o,
    output ch_cfg_t   [NCH-1:0]   cfg_o
);
    typedef struct packed {
        cnt_word_t [NCH-1:0] word;
        logic [REG_W-1:0]    ctrl;
    } regs_t;

    regs_t r_d, r_q;
    logic [1:0] idx;

    assign idx = bus_addr_i[3:2];

    always_comb begin
        r_d = r_q;
        if (bus_en_i && bus_wr_i) begin
            case (idx)
                2'd0:    r_d.word[0] = bus_wdata_i;
                2'd1:    r_d.word[1] = bus_wdata_i;
                2'd2:    r_d.ctrl    = bus_wdata_i & CTRL_MASK;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        case (idx)
            2'd0:    bus_rdata_o = r_q.word[0];
            2'd1:    bus_rdata_o = r_q.word[1];
            2'd2:    bus_rdata_o = r_q.ctrl;
            default: bus_rdata_o = '0;
        endcase
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_decode
        assign word_o[ch]        = r_q.word[ch];
        assign cfg_o[ch].out_en  = r_q.ctrl[oe_bit(ch)];
        assign cfg_o[ch].sel     = r_q.ctrl[sel_lsb(ch) +: SEL_W];
        assign cfg_o[ch].div     = r_q.ctrl[div_lsb(ch) +: DIV_W];
        assign cfg_o[ch].clk_en  = r_q.ctrl[gate_bit(ch)];
    end
endmodule

// File: rtl/dtp_prescaler.sv
module dtp_prescaler #(
    parameter int DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             src_tick_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] pcnt_d, pcnt_q;
    logic             wrap;

    assign wrap   = (pcnt_q >= div_i);
    assign tick_o = run_i && src_tick_i && wrap;

    always_comb begin
        pcnt_d = pcnt_q;
        if (!run_i)          pcnt_d = '0;
        else if (src_tick_i) pcnt_d = wrap ? '0 : pcnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pcnt_q <= '0;
        else        pcnt_q <= pcnt_d;
    end
endmodule

// File: rtl/dtp_channel.sv
module dtp_channel
    import dtp_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      run_i,
    input  logic      tick_i,
    input  cnt_word_t word_i,
    output logic      pwm_o
);
    typedef struct packed {
        logic        busy;
        logic        high;
        logic [CNT_W-1:0] cnt;
        cnt_word_t   act;
    } ch_state_t;

    ch_state_t s_d, s_q;
    logic [CNT_W:0] cnt_nx;

    assign cnt_nx = {1'b0, s_q.cnt} + 1'b1;

    always_comb begin
        s_d = s_q;
        if (!run_i) begin
            s_d.busy = 1'b0;
            s_d.high = 1'b0;
            s_d.cnt  = '0;
            s_d.act  = word_i;
        end else if (!s_q.busy) begin
            // start of the first period with the word present now
            s_d.busy = 1'b1;
            s_d.act  = word_i;
            s_d.high = (word_i.hi != '0);
            s_d.cnt  = '0;
        end else if (tick_i) begin
            if (s_q.high && (cnt_nx < {1'b0, s_q.act.hi})) begin
                s_d.cnt = cnt_nx[CNT_W-1:0];
            end else if (s_q.high && (s_q.act.lo != '0)) begin
                s_d.high = 1'b0;
                s_d.cnt  = '0;
            end else if (!s_q.high && (cnt_nx < {1'b0, s_q.act.lo})) begin
                s_d.cnt = cnt_nx[CNT_W-1:0];
            end else begin
                // period boundary: take the programmed word
                s_d.act  = word_i;
                s_d.high = (word_i.hi != '0);
                s_d.cnt  = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pwm_o = run_i && s_q.busy && s_q.high;
endmodule

// File: rtl/dual_tick_pwm.sv
module dual_tick_pwm
    import dtp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_en_i,
    input  logic             bus_wr_i,
    input  logic [3:0]       bus_addr_i,
    input  logic [31:0]      bus_wdata_i,
    output logic [31:0]      bus_rdata_o,
    input  logic [3:0]       src_tick_i,
    output logic             pwm_a_o,
    output logic             pwm_b_o
);
    cnt_word_t [NCH-1:0] word;
    ch_cfg_t   [NCH-1:0] cfg;
    logic      [NCH-1:0] run;
    logic      [NCH-1:0] dtick;
    logic      [NCH-1:0] pwm;

    dtp_regfile u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_en_i    (bus_en_i),
        .bus_wr_i    (bus_wr_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_rdata_o (bus_rdata_o),
        .word_o      (word),
        .cfg_o       (cfg)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic src_sel;
        assign src_sel = src_tick_i[cfg[ch].sel];
        assign run[ch] = cfg[ch].out_en && cfg[ch].clk_en;

        dtp_prescaler #(.DIV_W(DIV_W)) u_pre (
            .clk        (clk),
            .rst_n      (rst_n),
            .run_i      (run[ch]),
            .src_tick_i (src_sel),
            .div_i      (cfg[ch].div),
            .tick_o     (dtick[ch])
        );

        dtp_channel u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .run_i  (run[ch]),
            .tick_i (dtick[ch]),
            .word_i (word[ch]),
            .pwm_o  (pwm[ch])
        );
    end

    assign pwm_a_o = pwm[0];
    assign pwm_b_o = pwm[1];
endmodule

// File: rtl/dtp_checker.sv
module dtp_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_en,
    input logic        bus_wr,
    input logic [3:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic [31:0] word_a,
    input logic [31:0] word_b,
    input logic [1:0]  run,
    input logic [1:0]  dtick,
    input logic [1:0]  pwm
);
    // R1
    a_r1_word_a_write: assert property (@(posedge clk) disable iff (!rst_n)
        bus_en && bus_wr && bus_addr[3:2] == 2'd0 |=> word_a == $past(bus_wdata));
    a_r1_word_b_write: assert property (@(posedge clk) disable iff (!rst_n)
        bus_en && bus_wr && bus_addr[3:2] == 2'd1 |=> word_b == $past(bus_wdata));
    // R2
    a_r2_ctrl_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr[3:2] == 2'd2 |-> (bus_rdata & ~32'h00FF_FFF3) == 32'h0);
    // R3
    a_r3_idle_low_a: assert property (@(posedge clk) disable iff (!rst_n)
        !run[0] |-> !pwm[0]);
    a_r3_idle_low_b: assert property (@(posedge clk) disable iff (!rst_n)
        !run[1] |-> !pwm[1]);
    // R10
    a_r10_rise_a: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm[0]) |-> $past(dtick[0]) || ($past(run[0]) && !$past(run[0], 2)));
    a_r10_rise_b: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm[1]) |-> $past(dtick[1]) || ($past(run[1]) && !$past(run[1], 2)));
    a_r10_fall_a: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwm[0]) |-> $past(dtick[0]) || !run[0]);
    a_r10_fall_b: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwm[1]) |-> $past(dtick[1]) || !run[1]);
endmodule

bind dual_tick_pwm dtp_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en_i),
    .bus_wr    (bus_wr_i),
    .bus_addr  (bus_addr_i),
    .bus_wdata (bus_wdata_i),
    .bus_rdata (bus_rdata_o),
    .word_a    (word[0]),
    .word_b    (word[1]),
    .run       (run),
    .dtick     (dtick),
    .pwm       (pwm)
);

// File: tb/tb_dual_tick_pwm.sv
module tb_dual_tick_pwm;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0, bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  src_tick = 4'b0001;
    logic        pwm_a, pwm_b;
    int          n_chk = 0, n_fail = 0;
    int          tcnt = 0;

    dual_tick_pwm dut (
        .clk(clk), .rst_n(rst_n), .bus_en_i(bus_en), .bus_wr_i(bus_wr),
        .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
        .src_tick_i(src_tick), .pwm_a_o(pwm_a), .pwm_b_o(pwm_b)
    );

    always #5 clk = ~clk;

    // source 0 every cycle, 1 every 3rd, 2 never, 3 every 2nd
    always @(negedge clk) begin
        tcnt <= tcnt + 1;
        src_tick[1] <= ((tcnt + 1) % 3 == 0);
        src_tick[3] <= ((tcnt + 1) % 2 == 0);
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        summary();
        $finish;
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 0; bus_wr = 0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_en = 1; bus_wr = 0;
        #1 d = bus_rdata;
        bus_en = 0;
    endtask

    function automatic logic get_pwm(input int ch);
        return (ch == 0) ? pwm_a : pwm_b;
    endfunction

    function automatic logic [31:0] ctrl_for(input int ch, input int sel, input int div);
        logic [31:0] v = '0;
        v[ch] = 1'b1;
        v[4 + 2*ch +: 2] = sel[1:0];
        v[8 + 8*ch +: 7] = div[6:0];
        v[15 + 8*ch] = 1'b1;
        return v;
    endfunction

    function automatic int src_period(input int sel);
        return (sel == 1) ? 3 : (sel == 3) ? 2 : 1;
    endfunction

    function automatic int exp_len(input int n, input int div, input int sel);
        return n * (div + 1) * src_period(sel);
    endfunction

    task automatic wait_rise(input int ch);
        logic prev, cur;
        cur = get_pwm(ch);
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            prev = cur; cur = get_pwm(ch);
            if (!prev && cur) return;
        end
    endtask

    // called right after a rise has been seen; returns at the next rise
    task automatic count_hl(input int ch, output int h, output int l);
        h = 1; l = 0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (get_pwm(ch)) h++; else break;
        end
        l = 1;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (!get_pwm(ch)) l++; else break;
        end
    endtask

    task automatic steady_run(input int ch, input int win, input logic lvl, input string req);
        int bad = 0;
        repeat (20) @(negedge clk);
        for (int i = 0; i < win; i++) begin
            @(negedge clk);
            if (get_pwm(ch) !== lvl) bad++;
        end
        check(bad == 0, req, bad, 0);
    endtask

    initial begin
        logic [31:0] rd;
        int h, l;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // reset state (R1, R3)
        check(pwm_a == 0 && pwm_b == 0, "R3 reset outputs", {pwm_a, pwm_b}, 0);
        rst_n = 1;
        bus_read(4'h0, rd); check(rd == 0, "R1 reset word A", rd, 0);
        bus_read(4'h8, rd); check(rd == 0, "R1 reset ctrl", rd, 0);

        // R1 readback
        bus_write(4'h0, 32'hDEAD_BEEF);
        bus_write(4'h4, 32'h1234_5678);
        bus_read(4'h0, rd); check(rd == 32'hDEAD_BEEF, "R1 word A", rd, 32'hDEAD_BEEF);
        bus_read(4'h4, rd); check(rd == 32'h1234_5678, "R1 word B", rd, 32'h1234_5678);
        bus_read(4'hC, rd); check(rd == 0, "R1 offset C", rd, 0);
        // R2 spare bits
        bus_write(4'h8, 32'hFFFF_FFFF);
        bus_read(4'h8, rd); check(rd == 32'h00FF_FFF3, "R2 ctrl mask", rd, 32'h00FF_FFF3);
        bus_write(4'h8, 32'h0);

        // R4 R5 R6 random configurations
        for (int it = 0; it < 10; it++) begin
            int ch, hi, lo, dv, sel, sr;
            ch = $urandom_range(0, 1);
            hi = $urandom_range(1, 12);
            lo = $urandom_range(1, 12);
            dv = $urandom_range(0, 3);
            sr = $urandom_range(0, 2);
            sel = (sr == 0) ? 0 : (sr == 1) ? 1 : 3;
            bus_write(4'h8, 32'h0);
            bus_write(ch ? 4'h4 : 4'h0, {hi[15:0], lo[15:0]});
            bus_write(4'h8, ctrl_for(ch, sel, dv));
            wait_rise(ch);
            count_hl(ch, h, l);
            count_hl(ch, h, l);
            check(h == exp_len(hi, dv, sel), "R6 R5 R4 high length", h, exp_len(hi, dv, sel));
            check(l == exp_len(lo, dv, sel), "R6 R5 R4 low length", l, exp_len(lo, dv, sel));
        end

        // R9 both channels at once
        bus_write(4'h8, 32'h0);
        bus_write(4'h0, {16'd3, 16'd5});
        bus_write(4'h4, {16'd7, 16'd2});
        bus_write(4'h8, ctrl_for(0, 0, 0) | ctrl_for(1, 3, 1));
        wait_rise(0); count_hl(0, h, l); count_hl(0, h, l);
        check(h == 3 && l == 5, "R9 channel A", {h, l}, {32'd3, 32'd5});
        wait_rise(1); count_hl(1, h, l); count_hl(1, h, l);
        check(h == exp_len(7, 1, 3) && l == exp_len(2, 1, 3), "R9 channel B",
              {h, l}, {exp_len(7, 1, 3), exp_len(2, 1, 3)});

        // R7 constant levels
        bus_write(4'h8, 32'h0);
        bus_write(4'h0, {16'd0, 16'd5});
        bus_write(4'h8, ctrl_for(0, 0, 0));
        steady_run(0, 100, 1'b0, "R7 high count zero");
        bus_write(4'h8, 32'h0);
        bus_write(4'h0, {16'd5, 16'd0});
        bus_write(4'h8, ctrl_for(0, 0, 0));
        steady_run(0, 100, 1'b1, "R7 low count zero");
        // R3 clearing the clock gate drops the output at once
        bus_write(4'h8, ctrl_for(0, 0, 0) & ~32'h0000_8000);
        check(pwm_a == 0, "R3 gate cleared", pwm_a, 0);
        steady_run(0, 40, 1'b0, "R3 gate held low");
        bus_write(4'h8, ctrl_for(0, 0, 0));
        steady_run(0, 40, 1'b1, "R3 restart high");
        bus_write(4'h8, ctrl_for(0, 0, 0) & ~32'h1);
        check(pwm_a == 0, "R3 output enable cleared", pwm_a, 0);
        bus_write(4'h8, 32'h0);
        bus_write(4'h0, 32'h0);
        bus_write(4'h8, ctrl_for(0, 0, 0));
        steady_run(0, 100, 1'b0, "R7 both counts zero");

        // R8 mid-period rewrite
        bus_write(4'h8, 32'h0);
        bus_write(4'h0, {16'd10, 16'd10});
        bus_write(4'h8, ctrl_for(0, 0, 0));
        wait_rise(0); count_hl(0, h, l);
        fork
            begin
                repeat (2) @(negedge clk);
                bus_write(4'h0, {16'd3, 16'd3});
            end
        join_none
        count_hl(0, h, l);
        check(h == 10 && l == 10, "R8 current period kept", {h, l}, {32'd10, 32'd10});
        count_hl(0, h, l);
        check(h == 3 && l == 3, "R8 new word next period", {h, l}, {32'd3, 32'd3});

        summary();
        $finish;
    end
endmodule